// File: doc/BRIEF.md
# Aligned 16-byte block copy engine

This block is a sequencer inside a 32-bit processor datapath that carries out one post-increment line-copy instruction. When started it takes a 16-bit instruction word and a 16-bit extension word, checks that both match the instruction's fixed encoding, and picks the source and destination address-register numbers out of them. It then reads both register values through a single register-file read port.

Both addresses must sit on a 16-byte boundary. The source address is tested first, then the destination. A misaligned line ends the instruction with an address fault. The fault reports the offending address and whether the failed access was a read or a write. No memory access is made and neither register changes.

An aligned line is copied as four 32-bit words over a valid/ready memory bus. Each word is read and then written before the next read starts. Both registers are then written back advanced by 16. Completion reports a cycle cost. The block has no condition-code outputs.

Top module: `line_copy_engine`

## Requirements
- R1: The instruction word must equal 0xF620 with any value in bits 2:0. The extension word must have bit 15 set and bits 11:0 clear. For any other pair the engine pulses `illegal` for one cycle, makes no memory access and writes no register.
- R2: The source register number is instruction bits 2:0. The destination register number is extension bits 14:12.
- R3: If the low 4 bits of the source address are nonzero, the engine pulses `fault` with `fault_addr` equal to the source address and `fault_is_write` = 0. It makes no memory access and no register write.
- R4: If the source is aligned but the low 4 bits of the destination address are nonzero, the engine pulses `fault` with `fault_addr` equal to the destination address and `fault_is_write` = 1. It makes no memory access and no register write.
- R5: A copy makes exactly eight bus transfers in this order: read src+0, write dst+0, read src+4, write dst+4, read src+8, write dst+8, read src+12, write dst+12. Each write carries the data of the read just before it.
- R6: After a copy, the source register and then the destination register are written with their original values plus 16, modulo 2^32.
- R7: `cycle_cost` is 4 in the `done` cycle and 0 in a `fault` or `illegal` cycle.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged into the next cycle. Any number of stall cycles is allowed.
- R9: When source and destination are the same register, it ends at its original value plus 16, not plus 32.
- R10: `busy` is high from the cycle after an accepted start until the cycle that ends the instruction. In that ending cycle exactly one of `done`, `fault` or `illegal` is high for one cycle and `busy` is low. A start seen while the engine is not idle is ignored.
- R11: Asserting `rst_n` low at once returns the engine to idle. `mem_valid`, `busy`, `rf_wr_en`, `fault`, `fault_addr` and `fault_is_write` all go low, and no further bus or register activity follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through two flops |
| start | input | 1 | Start strobe, taken only when idle |
| opcode | input | 16 | Instruction word |
| ext_word | input | 16 | Extension word |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle successful completion |
| fault | output | 1 | One-cycle address fault |
| illegal | output | 1 | One-cycle illegal-encoding report |
| fault_addr | output | 32 | Misaligned address of the last fault |
| fault_is_write | output | 1 | Last fault was on the write side |
| cycle_cost | output | 4 | Cost reported with the ending pulse |
| rf_rd_idx | output | 3 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data, same cycle |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 3 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
Two events can meet in one cycle: a new start request and the one-cycle ending pulse of the running instruction. The engine is not idle in that cycle, so the request must be dropped. The bench holds `start` high from acceptance through the `done` cycle. It then checks that exactly one copy happened (eight bus transfers and two register writes) and that `busy` stays low afterwards. A second meeting is a memory stall against the read-to-write step. Stalls of several cycles are inserted on every transfer, and the data in the destination line is compared with a copy of the source taken beforehand.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEC,
    S_RD_SRC,
    S_RD_DST,
    S_CHK,
    S_MRD,
    S_MWR,
    S_WBS,
    S_WBD,
    S_FIN,
    S_FLT,
    S_ILL
  } lc_state_e;

  localparam int          REG_IDX_W  = 3;
  localparam logic [12:0] OPC_FIXED  = 13'b1111_0110_0010_0;
  localparam logic [11:0] EXT_ZEROES = 12'h000;

endpackage

// File: rtl/lc_decode.sv
module lc_decode
  import lc_pkg::*;
(
  input  logic [15:0]          opcode,
  input  logic [15:0]          ext_word,
  output logic                 legal,
  output logic [REG_IDX_W-1:0] src_idx,
  output logic [REG_IDX_W-1:0] dst_idx
);

  logic opc_ok;
  logic ext_ok;

  always_comb begin
    opc_ok  = (opcode[15:3] == OPC_FIXED);
    ext_ok  = ext_word[15] && (ext_word[11:0] == EXT_ZEROES);
    legal   = opc_ok && ext_ok;
    src_idx = opcode[2:0];
    dst_idx = ext_word[14:12];
  end

endmodule

// File: rtl/lc_align.sv
module lc_align #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              misalign,
  output logic [ADDR_W-1:0] bad_addr,
  output logic              bad_is_write
);

  localparam int ALIGN_BITS = $clog2(LINE_BYTES);

  logic src_bad;
  logic dst_bad;

  always_comb begin
    src_bad  = |src_addr[ALIGN_BITS-1:0];
    dst_bad  = |dst_addr[ALIGN_BITS-1:0];
    misalign = src_bad || dst_bad;
    // source side has priority
    if (src_bad) begin
      bad_addr     = src_addr;
      bad_is_write = 1'b0;
    end else begin
      bad_addr     = dst_addr;
      bad_is_write = 1'b1;
    end
  end

endmodule

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              legal,
  input  logic              misalign,
  input  logic              mem_ready,
  output lc_state_e         state,
  output logic [BEAT_W-1:0] beat
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  lc_state_e         state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              beat_en;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    beat_en = 1'b0;
    unique case (state_q)
      S_IDLE:   if (start) state_d = S_DEC;
      S_DEC:    state_d = legal ? S_RD_SRC : S_ILL;
      S_RD_SRC: state_d = S_RD_DST;
      S_RD_DST: state_d = S_CHK;
      S_CHK: begin
        beat_d  = '0;
        beat_en = 1'b1;
        state_d = misalign ? S_FLT : S_MRD;
      end
      S_MRD:    if (mem_ready) state_d = S_MWR;
      S_MWR: begin
        if (mem_ready) begin
          beat_d  = beat_q + 1'b1;
          beat_en = 1'b1;
          state_d = (beat_q == LAST_BEAT) ? S_WBS : S_MRD;
        end
      end
      S_WBS:    state_d = S_WBD;
      S_WBD:    state_d = S_FIN;
      S_FIN, S_FLT, S_ILL: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  assign state = state_q;
  assign beat  = beat_q;

endmodule

// File: rtl/line_copy_engine.sv
module line_copy_engine
  import lc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int COST_W     = 4,
  parameter int COST_OK    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [15:0]          opcode,
  input  logic [15:0]          ext_word,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic                 illegal,
  output logic [ADDR_W-1:0]    fault_addr,
  output logic                 fault_is_write,
  output logic [COST_W-1:0]    cycle_cost,
  output logic [REG_IDX_W-1:0] rf_rd_idx,
  input  logic [ADDR_W-1:0]    rf_rd_data,
  output logic                 rf_wr_en,
  output logic [REG_IDX_W-1:0] rf_wr_idx,
  output logic [ADDR_W-1:0]    rf_wr_data,
  output logic                 mem_valid,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic                 mem_ready,
  input  logic [DATA_W-1:0]    mem_rdata
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BEATS      = LINE_BYTES / WORD_BYTES;
  localparam int BEAT_W     = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

  // reset: asserted at once, released after two clocks
  logic rst_meta_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  lc_state_e            state;
  logic [BEAT_W-1:0]    beat;
  logic                 legal;
  logic                 misalign;
  logic [REG_IDX_W-1:0] src_idx;
  logic [REG_IDX_W-1:0] dst_idx;
  logic [ADDR_W-1:0]    bad_addr;
  logic                 bad_is_write;

  logic [15:0]          op_q, ext_q;
  logic [ADDR_W-1:0]    src_q, dst_q;
  logic [DATA_W-1:0]    data_q;
  logic [ADDR_W-1:0]    faddr_q;
  logic                 fwr_q;

  logic                 op_en, src_en, dst_en, data_en, flt_en;
  logic [ADDR_W-1:0]    offset;

  lc_ctrl #(
    .BEATS  (BEATS),
    .BEAT_W (BEAT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .legal     (legal),
    .misalign  (misalign),
    .mem_ready (mem_ready),
    .state     (state),
    .beat      (beat)
  );

  lc_decode u_dec (
    .opcode   (op_q),
    .ext_word (ext_q),
    .legal    (legal),
    .src_idx  (src_idx),
    .dst_idx  (dst_idx)
  );

  lc_align #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_align (
    .src_addr     (src_q),
    .dst_addr     (dst_q),
    .misalign     (misalign),
    .bad_addr     (bad_addr),
    .bad_is_write (bad_is_write)
  );

  // enables
  always_comb begin
    op_en   = (state == S_IDLE) && start;
    src_en  = (state == S_RD_SRC);
    dst_en  = (state == S_RD_DST);
    data_en = (state == S_MRD) && mem_ready;
    flt_en  = (state == S_CHK) && misalign;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q  <= '0;
      ext_q <= '0;
    end else if (op_en) begin
      op_q  <= opcode;
      ext_q <= ext_word;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      src_q <= '0;
    end else if (src_en) begin
      src_q <= rf_rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dst_q <= '0;
    end else if (dst_en) begin
      dst_q <= rf_rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      faddr_q <= '0;
      fwr_q   <= 1'b0;
    end else if (flt_en) begin
      faddr_q <= bad_addr;
      fwr_q   <= bad_is_write;
    end
  end

  // outputs
  always_comb begin
    offset         = ADDR_W'(beat) << WORD_SHIFT;
    busy           = !(state inside {S_IDLE, S_FIN, S_FLT, S_ILL});
    done           = (state == S_FIN);
    fault          = (state == S_FLT);
    illegal        = (state == S_ILL);
    cycle_cost     = done ? COST_W'(COST_OK) : '0;
    fault_addr     = faddr_q;
    fault_is_write = fwr_q;

    rf_rd_idx      = (state == S_RD_DST) ? dst_idx : src_idx;
    rf_wr_en       = (state == S_WBS) || (state == S_WBD);
    rf_wr_idx      = (state == S_WBD) ? dst_idx : src_idx;
    rf_wr_data     = ((state == S_WBD) ? dst_q : src_q) + LINE_STEP;

    mem_valid      = (state == S_MRD) || (state == S_MWR);
    mem_we         = (state == S_MWR);
    mem_addr       = ((state == S_MWR) ? dst_q : src_q) + offset;
    mem_wdata      = data_q;
  end

endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int COST_W  = 4,
  parameter int COST_OK = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              illegal,
  input logic [COST_W-1:0] cycle_cost,
  input logic              rf_wr_en,
  input logic              mem_valid,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R8

  AST_ONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault, illegal})); // R10

  AST_END_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault || illegal) |-> !busy); // R10

  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault || illegal) |=> !(done || fault || illegal)); // R10

  AST_COST_OK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycle_cost == COST_W'(COST_OK))); // R7

  AST_COST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || illegal) |-> (cycle_cost == '0)); // R7

  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00)); // R5

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!rf_wr_en && !mem_valid && !$past(mem_valid))); // R3

endmodule

bind line_copy_engine lc_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .COST_W  (COST_W),
  .COST_OK (COST_OK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .fault      (fault),
  .illegal    (illegal),
  .cycle_cost (cycle_cost),
  .rf_wr_en   (rf_wr_en),
  .mem_valid  (mem_valid),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready)
);

// File: tb/sim_line_copy_engine.sv
module sim_line_copy_engine;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] opcode;
  logic [15:0] ext_word;
  logic        busy, done, fault, illegal;
  logic [31:0] fault_addr;
  logic        fault_is_write;
  logic [3:0]  cycle_cost;
  logic [2:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic        rf_wr_en;
  logic [2:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic        mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  line_copy_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .ext_word(ext_word),
    .busy(busy), .done(done), .fault(fault), .illegal(illegal),
    .fault_addr(fault_addr), .fault_is_write(fault_is_write), .cycle_cost(cycle_cost),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // register file and memory models
  logic [31:0] rf  [0:7];
  logic [31:0] mem [0:255];
  assign rf_rd_data = rf[rf_rd_idx];
  assign mem_rdata  = mem[mem_addr[9:2]];

  int wr_cnt = 0;
  always @(posedge clk) begin
    if (rf_wr_en) begin
      rf[rf_wr_idx] <= rf_wr_data;
      wr_cnt = wr_cnt + 1;
    end
  end

  logic [31:0] log_addr [0:63];
  logic        log_we   [0:63];
  int          log_n = 0;
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      log_addr[log_n % 64] = mem_addr;
      log_we[log_n % 64]   = mem_we;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      log_n = log_n + 1;
    end
  end

  int stall_cfg = 0;
  int wait_cnt  = 0;
  always @(negedge clk) begin
    if (!rst_n || !mem_valid) begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end else if (wait_cnt >= stall_cfg) begin
      mem_ready = 1'b1;
      wait_cnt  = 0;
    end else begin
      mem_ready = 1'b0;
      wait_cnt  = wait_cnt + 1;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // results of the last run: 0 none, 1 done, 2 fault, 3 illegal
  int          res_kind;
  logic [3:0]  res_cost;
  logic        res_busy;
  logic [31:0] res_faddr;
  logic        res_fwr;
  int          log_base;
  int          wr_base;

  task automatic run(input logic [15:0] op, input logic [15:0] ext, input bit hold_start);
    @(negedge clk);
    log_base = log_n;
    wr_base  = wr_cnt;
    opcode   = op;
    ext_word = ext;
    start    = 1'b1;
    res_kind = 0;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done || fault || illegal) begin
        res_kind  = done ? 1 : (fault ? 2 : 3);
        res_cost  = cycle_cost;
        res_busy  = busy;
        res_faddr = fault_addr;
        res_fwr   = fault_is_write;
        break;
      end
      if (hold_start) chk("R10 busy while running", {31'b0, busy}, 32'd1);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 busy after reset", {31'b0, busy}, 32'd0);
    chk("R11 mem_valid after reset", {31'b0, mem_valid}, 32'd0);
    chk("R11 fault after reset", {31'b0, fault}, 32'd0);
    chk("R11 fault_addr after reset", fault_addr, 32'd0);
    chk("R10 done after reset", {31'b0, done}, 32'd0);
  endtask

  // copy: src reg s, dst reg d
  task automatic t_copy(input int s, input int d, input logic [31:0] sa,
                        input logic [31:0] da, input int stall, input string tag);
    logic [31:0] snap [0:3];
    logic [31:0] exp_s, exp_d;
    @(negedge clk);
    stall_cfg = stall;
    rf[s] = sa;
    rf[d] = da;
    for (int i = 0; i < 4; i++) snap[i] = mem[(sa[9:2] + i) % 256];
    run(16'hF620 | 16'(s), 16'h8000 | (16'(d) << 12), 1'b0);
    exp_s = (s == d) ? sa + 32'd16 : sa + 32'd16;
    exp_d = (s == d) ? sa + 32'd16 : da + 32'd16;
    chk({tag, " R7 done seen"}, res_kind, 32'd1);
    chk({tag, " R7 cost 4"}, {28'b0, res_cost}, 32'd4);
    chk({tag, " R10 busy low at done"}, {31'b0, res_busy}, 32'd0);
    chk({tag, " R5 transfer count"}, log_n - log_base, 32'd8);
    for (int i = 0; i < 4; i++) begin
      chk({tag, " R5 read addr"},  log_addr[(log_base + 2*i) % 64], sa + 32'(4*i));
      chk({tag, " R5 read dir"},   {31'b0, log_we[(log_base + 2*i) % 64]}, 32'd0);
      chk({tag, " R5 write addr"}, log_addr[(log_base + 2*i + 1) % 64], da + 32'(4*i));
      chk({tag, " R5 write dir"},  {31'b0, log_we[(log_base + 2*i + 1) % 64]}, 32'd1);
      chk({tag, " R5 R8 data"},    mem[(da[9:2] + i) % 256], snap[i]);
    end
    chk({tag, " R6 two reg writes"}, wr_cnt - wr_base, 32'd2);
    chk({tag, " R2 R6 src reg"}, rf[s], exp_s);
    chk({tag, " R2 R6 R9 dst reg"}, rf[d], exp_d);
  endtask

  task automatic t_fault(input logic [31:0] sa, input logic [31:0] da,
                         input logic [31:0] exp_addr, input bit exp_wr, input string tag);
    @(negedge clk);
    rf[4] = sa;
    rf[6] = da;
    run(16'hF624, 16'hE000, 1'b0);
    chk({tag, " fault seen"}, res_kind, 32'd2);
    chk({tag, " fault addr"}, res_faddr, exp_addr);
    chk({tag, " fault dir"}, {31'b0, res_fwr}, {31'b0, exp_wr});
    chk({tag, " R7 cost 0"}, {28'b0, res_cost}, 32'd0);
    chk({tag, " no bus"}, log_n - log_base, 32'd0);
    chk({tag, " no reg write"}, wr_cnt - wr_base, 32'd0);
    chk({tag, " src kept"}, rf[4], sa);
    chk({tag, " dst kept"}, rf[6], da);
  endtask

  task automatic t_illegal(input logic [15:0] op, input logic [15:0] ext);
    @(negedge clk);
    rf[1] = 32'h0000_0100;
    run(op, ext, 1'b0);
    chk("R1 illegal seen", res_kind, 32'd3);
    chk("R1 R7 cost 0", {28'b0, res_cost}, 32'd0);
    chk("R1 no bus", log_n - log_base, 32'd0);
    chk("R1 no reg write", wr_cnt - wr_base, 32'd0);
  endtask

  // start held high across the done cycle
  task automatic t_busy_overlap;
    @(negedge clk);
    stall_cfg = 1;
    rf[0] = 32'h0000_0080;
    rf[3] = 32'h0000_0180;
    run(16'hF620, 16'hB000, 1'b1);
    chk("R10 done with start held", res_kind, 32'd1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 start ignored, busy low", {31'b0, busy}, 32'd0);
    end
    chk("R10 single copy transfers", log_n - log_base, 32'd8);
    chk("R10 single copy writes", wr_cnt - wr_base, 32'd2);
    chk("R10 src once", rf[0], 32'h0000_0090);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    stall_cfg = 5;
    rf[5] = 32'h0000_0300;
    rf[7] = 32'h0000_0380;
    opcode   = 16'hF625;
    ext_word = 16'hF000;
    start    = 1'b1;
    wr_base  = wr_cnt;
    @(negedge clk);
    start = 1'b0;
    while (!mem_valid) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 mem_valid cleared", {31'b0, mem_valid}, 32'd0);
    chk("R11 busy cleared", {31'b0, busy}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    log_base = log_n;
    repeat (10) @(negedge clk);
    chk("R11 no bus after reset", log_n - log_base, 32'd0);
    chk("R11 no reg write", wr_cnt - wr_base, 32'd0);
    chk("R11 reg kept", rf[5], 32'h0000_0300);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    opcode = '0;
    ext_word = '0;
    mem_ready = 1'b0;
    for (int i = 0; i < 8; i++) rf[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hC3A5_0000 ^ (32'(i) * 32'h0101_0107);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    t_copy(3, 5, 32'h0000_0100, 32'h0000_0200, 0, "basic");
    t_copy(0, 7, 32'h0000_0340, 32'h0000_03C0, 3, "stall");
    t_copy(1, 2, 32'hFFFF_FFF0, 32'h0000_0080, 1, "wrap");
    t_copy(2, 2, 32'h0000_0040, 32'h0000_0040, 2, "same R9");
    t_fault(32'h0000_0104, 32'h0000_0208, 32'h0000_0104, 1'b0, "R3");
    t_fault(32'h0000_0100, 32'h0000_0208, 32'h0000_0208, 1'b1, "R4");
    t_illegal(16'hF62B, 16'hD000);
    t_illegal(16'hF623, 16'h5000);
    t_illegal(16'hF623, 16'hD001);
    t_busy_overlap;
    t_reset_mid;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule